// File: doc/BRIEF.md
# PCI Interrupt Line Router

This block steers level-sensitive interrupt pins from a set of PCI device slots onto the sixteen inputs of a legacy interrupt controller. Each slot has four pins, INTA to INTD. The block rotates each slot's pins by the slot position and folds them onto four shared PIRQ lines, named A to D. A PIRQ line is the OR of every pin that lands on it.

Each PIRQ line has a one-byte route register. The route byte either names one of the sixteen controller inputs or, for any value of 16 and up, disconnects the line. Each output is registered and is the OR of every enabled PIRQ whose route names it. A change on an input pin or on a route byte therefore shows up on the outputs one clock later, all at once, with no mix of old and new routes.

Firmware uses a small byte-addressed port to write and read the route bytes. The current enable and target of every PIRQ are also visible on dedicated outputs.

Top module: `pci_irq_steer`

## Requirements
- R1: After reset, all four route bytes hold 0x80, every PIRQ reports disabled, and all sixteen outputs are low.
- R2: A route byte below 16 sends its PIRQ to the output whose index equals the byte value.
- R3: A route byte of 16 or above disconnects its PIRQ, so that line drives no output. The values 0x10 and 0xFF are included.
- R4: Two or more enabled PIRQs may name the same output. That output stays high while any of them is high and falls only when all of them are low.
- R5: Pin p of slot s (INTA=0 to INTD=3, slots numbered from 1) lands on PIRQ (p + s − 1) mod 4, where PIRQ A=0 and D=3. Slot 1 is not rotated.
- R6: A PIRQ line is high when any pin that lands on it is high.
- R7: For each PIRQ, route_en is 1 and route_num holds the target when the byte is below 16. Otherwise route_en is 0 and route_num is 0.
- R8: The route bytes for PIRQ A, B, C and D sit at port offsets 0x60, 0x61, 0x62 and 0x63. A read returns the full stored byte on the cycle after the read strobe. Any other offset reads 0, and cfg_rdata is 0 in a cycle that follows no read.
- R9: A write to any offset outside 0x60 to 0x63 changes no route byte and no output.
- R10: The outputs are registered. Output values in a cycle are computed from the pin levels and route bytes of the previous cycle, so a change on a pin or a route byte appears exactly one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| slot_int | input | 4*NUM_SLOTS | Pin levels; bit 4*(s−1)+p is pin p of slot s |
| cfg_addr | input | 8 | Port byte offset |
| cfg_wdata | input | 8 | Write data |
| cfg_wr | input | 1 | Write strobe |
| cfg_rd | input | 1 | Read strobe |
| cfg_rdata | output | 8 | Read data, valid one cycle after cfg_rd |
| irq_out | output | NUM_IRQS | Level outputs to the interrupt controller |
| route_en | output | 4 | Per PIRQ: route byte is below 16 |
| route_num | output | 4*IW | Per PIRQ target (IW bits each), 0 when disabled |

## Verification
The bench first drives single pins on each slot, so each rotation is seen on its own. Slot 1 shows the case with no rotation, and slots 2 to 4 show the pin-to-PIRQ mapping shifting by one per slot. Pin pairs that land on the same PIRQ, and PIRQ pairs routed to one output, are then raised and dropped one at a time. This separates the OR at the pin level from the OR at the output level. Route bytes at 15, 16 and 0xFF mark the edge between routed and disconnected, and writes to offsets next to the route window (0x5F, 0x64) show that they reach no route byte. A random phase then mixes pin changes with route writes in the same cycle, which checks that outputs follow the previous cycle's routes.

// File: rtl/pci_irq_steer.sv
module pci_irq_steer #(
  parameter int          NUM_SLOTS  = 4,
  parameter int          NUM_IRQS   = 16,
  parameter logic [7:0]  ROUTE_BASE = 8'h60,
  parameter logic [7:0]  ROUTE_RST  = 8'h80
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [4*NUM_SLOTS-1:0]      slot_int,
  input  logic [7:0]                  cfg_addr,
  input  logic [7:0]                  cfg_wdata,
  input  logic                        cfg_wr,
  input  logic                        cfg_rd,
  output logic [7:0]                  cfg_rdata,
  output logic [NUM_IRQS-1:0]         irq_out,
  output logic [3:0]                  route_en,
  output logic [4*$clog2(NUM_IRQS)-1:0] route_num
);
  localparam int         NPIRQ = 4;
  localparam int         IW    = $clog2(NUM_IRQS);
  localparam logic [7:0] LIMIT = 8'(NUM_IRQS);

  logic [7:0]          route_q [NPIRQ];
  logic [NPIRQ-1:0]    pirq_lvl;
  logic [NUM_IRQS-1:0] irq_next;
  logic                win_hit;

  assign win_hit = (cfg_addr[7:2] == ROUTE_BASE[7:2]);

  for (genvar q = 0; q < NPIRQ; q++) begin : g_route
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        route_q[q] <= ROUTE_RST;
      else if (cfg_wr && win_hit && cfg_addr[1:0] == 2'(q))
        route_q[q] <= cfg_wdata;
    end
    assign route_en[q] = route_q[q] < LIMIT;
    assign route_num[q*IW +: IW] = route_en[q] ? route_q[q][IW-1:0] : '0;
  end

  always_comb begin
    pirq_lvl = '0;
    for (int s = 0; s < NUM_SLOTS; s++)
      for (int p = 0; p < 4; p++)
        if (slot_int[s*4+p]) pirq_lvl[(p + s) % NPIRQ] = 1'b1;
  end

  always_comb begin
    irq_next = '0;
    for (int q = 0; q < NPIRQ; q++)
      if (route_en[q] && pirq_lvl[q]) irq_next[route_q[q][IW-1:0]] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_out   <= '0;
      cfg_rdata <= '0;
    end else begin
      irq_out   <= irq_next;
      cfg_rdata <= (cfg_rd && win_hit) ? route_q[cfg_addr[1:0]] : 8'h00;
    end
  end
endmodule

module pci_irq_steer_chk #(
  parameter int          NUM_SLOTS  = 4,
  parameter int          NUM_IRQS   = 16,
  parameter logic [7:0]  ROUTE_BASE = 8'h60,
  parameter logic [7:0]  ROUTE_RST  = 8'h80
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic [4*NUM_SLOTS-1:0]        slot_int,
  input logic [7:0]                    cfg_addr,
  input logic                          cfg_wr,
  input logic                          cfg_rd,
  input logic [7:0]                    cfg_rdata,
  input logic [NUM_IRQS-1:0]           irq_out,
  input logic [3:0]                    route_en,
  input logic [4*$clog2(NUM_IRQS)-1:0] route_num
);
  localparam int IW = $clog2(NUM_IRQS);
  logic in_win;
  assign in_win = (cfg_addr[7:2] == ROUTE_BASE[7:2]);

  a_r3_all_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    route_en == 4'b0 |=> irq_out == '0);

  a_r6_no_pins_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    slot_int == '0 |=> irq_out == '0);

  a_r8_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_rd |=> cfg_rdata == 8'h00);

  a_r8_outside_zero: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rd && !in_win |=> cfg_rdata == 8'h00);

  a_r8_enabled_readback: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rd && in_win && route_en[cfg_addr[1:0]]
    |=> cfg_rdata < 8'(NUM_IRQS)
        && cfg_rdata[IW-1:0] == $past(route_num[cfg_addr[1:0]*IW +: IW]));

  a_r9_outside_write: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr && !in_win |=> $stable(route_en) && $stable(route_num));

  a_r7_disabled_num: assert property (@(posedge clk) disable iff (!rst_n)
    !route_en[0] |-> route_num[IW-1:0] == '0);
endmodule

bind pci_irq_steer pci_irq_steer_chk #(
  .NUM_SLOTS(NUM_SLOTS), .NUM_IRQS(NUM_IRQS),
  .ROUTE_BASE(ROUTE_BASE), .ROUTE_RST(ROUTE_RST)
) u_chk (.*);

// File: tb/tb_pci_irq_steer.sv
module tb_pci_irq_steer;
  localparam int NS = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4*NS-1:0] slot_int = '0;
  logic [7:0]  cfg_addr = '0, cfg_wdata = '0, cfg_rdata;
  logic        cfg_wr = 1'b0, cfg_rd = 1'b0;
  logic [15:0] irq_out;
  logic [3:0]  route_en;
  logic [15:0] route_num;

  int checks = 0, errors = 0;
  bit live = 0;
  int rb [4];
  logic [15:0] exp_out = '0;
  logic [7:0]  exp_rd = '0;

  always #5 clk = ~clk;

  pci_irq_steer #(.NUM_SLOTS(NS)) dut (.*);

  function automatic logic [15:0] ref_out(logic [4*NS-1:0] pins);
    logic [15:0] r = '0;
    for (int s = 1; s <= NS; s++)
      for (int p = 0; p < 4; p++)
        if (pins[(s-1)*4+p]) begin
          int k = (p + s - 1) % 4;
          if (rb[k] < 16) r[rb[k]] = 1'b1;
        end
    return r;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 4; i++) rb[i] = 128;
      exp_out = '0;
      exp_rd  = '0;
    end else begin
      exp_out = ref_out(slot_int);
      exp_rd  = (cfg_rd && cfg_addr >= 8'h60 && cfg_addr <= 8'h63) ? 8'(rb[cfg_addr - 8'h60]) : 8'h00;
      if (cfg_wr && cfg_addr >= 8'h60 && cfg_addr <= 8'h63) rb[cfg_addr - 8'h60] = int'(cfg_wdata);
    end
  end

  task automatic check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (live) begin
    check(irq_out == exp_out, "R10 outputs vs model", int'(irq_out), int'(exp_out));
    check(cfg_rdata == exp_rd, "R8 read data vs model", int'(cfg_rdata), int'(exp_rd));
    for (int q = 0; q < 4; q++) begin
      check(route_en[q] == (rb[q] < 16), "R7 route_en", int'(route_en[q]), int'(rb[q] < 16));
      check(int'(route_num[q*4 +: 4]) == (rb[q] < 16 ? rb[q] : 0), "R7 route_num",
            int'(route_num[q*4 +: 4]), rb[q] < 16 ? rb[q] : 0);
    end
  end

  task automatic wr(logic [7:0] a, logic [7:0] d);
    cfg_addr = a; cfg_wdata = d; cfg_wr = 1'b1;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [7:0] d);
    cfg_addr = a; cfg_rd = 1'b1;
    @(negedge clk);
    cfg_rd = 1'b0;
    d = cfg_rdata;
  endtask

  task automatic settle();
    repeat (2) @(negedge clk);
  endtask

  function automatic logic [4*NS-1:0] pin(int s, int p);
    logic [4*NS-1:0] v = '0;
    v[(s-1)*4+p] = 1'b1;
    return v;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    live = 1;
    // R1 reset state
    check(irq_out == 16'h0, "R1 outputs low", int'(irq_out), 0);
    check(route_en == 4'h0, "R1 all disabled", int'(route_en), 0);
    for (int q = 0; q < 4; q++) begin
      rd(8'(8'h60 + q), d);
      check(d == 8'h80, "R1 route byte reset", int'(d), 8'h80);
    end
    // R2 plain route, slot 1 unrotated
    wr(8'h60, 8'd5);
    slot_int = pin(1, 0);
    settle();
    check(irq_out == 16'h0020, "R2 PIRQ A to 5", int'(irq_out), 16'h0020);
    wr(8'h61, 8'd9);
    wr(8'h62, 8'd15);
    // R5 rotation
    slot_int = pin(2, 0); settle();
    check(irq_out == 16'h0200, "R5 slot2 INTA to B", int'(irq_out), 16'h0200);
    slot_int = pin(3, 3); settle();
    check(irq_out == 16'h0200, "R5 slot3 INTD to B", int'(irq_out), 16'h0200);
    slot_int = pin(4, 1); settle();
    check(irq_out == 16'h0020, "R5 slot4 INTB to A", int'(irq_out), 16'h0020);
    slot_int = pin(4, 3); settle();
    check(irq_out == 16'h8000, "R5 slot4 INTD to C at 15", int'(irq_out), 16'h8000);
    // R6 two pins on one PIRQ
    slot_int = pin(1, 1) | pin(2, 0); settle();
    check(irq_out == 16'h0200, "R6 both pins", int'(irq_out), 16'h0200);
    slot_int = pin(2, 0); settle();
    check(irq_out == 16'h0200, "R6 one pin left", int'(irq_out), 16'h0200);
    // R4 shared output
    wr(8'h62, 8'd5);
    slot_int = pin(1, 0) | pin(1, 2); settle();
    check(irq_out == 16'h0020, "R4 shared both high", int'(irq_out), 16'h0020);
    slot_int = pin(1, 2); settle();
    check(irq_out == 16'h0020, "R4 shared one high", int'(irq_out), 16'h0020);
    slot_int = '0; settle();
    check(irq_out == 16'h0000, "R4 shared both low", int'(irq_out), 0);
    // R3 disable thresholds
    slot_int = pin(1, 0);
    wr(8'h60, 8'h10); settle();
    check(irq_out == 16'h0000, "R3 byte 0x10 off", int'(irq_out), 0);
    check(route_en[0] == 1'b0, "R7 disabled flag", int'(route_en[0]), 0);
    wr(8'h60, 8'hFF); settle();
    check(irq_out == 16'h0000, "R3 byte 0xFF off", int'(irq_out), 0);
    rd(8'h60, d);
    check(d == 8'hFF, "R8 full byte kept", int'(d), 8'hFF);
    // R8 reads
    rd(8'h61, d);
    check(d == 8'd9, "R8 offset 0x61 is B", int'(d), 9);
    rd(8'h40, d);
    check(d == 8'h00, "R8 unmapped 0x40", int'(d), 0);
    rd(8'h64, d);
    check(d == 8'h00, "R8 unmapped 0x64", int'(d), 0);
    // R9 writes outside window
    slot_int = pin(2, 0);
    wr(8'h64, 8'd3);
    wr(8'h5F, 8'd3);
    settle();
    check(irq_out == 16'h0200, "R9 output unchanged", int'(irq_out), 16'h0200);
    rd(8'h61, d);
    check(d == 8'd9, "R9 route B unchanged", int'(d), 9);
    rd(8'h60, d);
    check(d == 8'hFF, "R9 route A unchanged", int'(d), 8'hFF);
    // R10 latency
    slot_int = '0; settle();
    slot_int = pin(2, 0);
    #4;
    check(irq_out == 16'h0, "R10 not before edge", int'(irq_out), 0);
    @(negedge clk);
    check(irq_out == 16'h0200, "R10 one clock later", int'(irq_out), 16'h0200);
    // random mix, compared every clock by the model
    for (int i = 0; i < 400; i++) begin
      slot_int  = 16'($urandom);
      cfg_addr  = 8'(8'h5E + $urandom_range(0, 7));
      cfg_wdata = ($urandom_range(0, 3) == 0) ? 8'($urandom) : 8'($urandom_range(0, 17));
      cfg_wr    = 1'($urandom);
      cfg_rd    = 1'($urandom);
      @(negedge clk);
    end
    cfg_wr = 1'b0; cfg_rd = 1'b0;
    @(negedge clk);
    live = 0;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule